// File: doc/BRIEF.md
# Stack Operation Sequencer

This block carries out the stack side of four control-flow and data instructions on a 32-bit machine: saving a word, restoring a word, entering a subroutine and leaving it. The surrounding pipeline hands it the current stack pointer and the operands. The block then makes one word access to a byte-addressed data memory and returns the new stack pointer, the word that moved, and, for subroutine entry and exit, the next program counter. A single-cycle completion pulse ends each operation.

The stack grows toward lower addresses, and the pointer always names the top element. A save moves the pointer down by one word and then writes at the new address. A restore reads at the current pointer and then moves the pointer up. Subroutine entry saves the address of the byte that follows its 5-byte instruction and then jumps. Subroutine exit restores a word and uses it as the next program counter. If an access would fall outside the memory, no access is made and a bad-address status is reported instead.

Top module: `stack_engine`

## Requirements
- R1: Push (op code 0) writes `src_data` to address `sp_in - 4`. It returns `sp_out = sp_in - 4` with `sp_we` set and `result = src_data`, and `pc_we` stays 0.
- R2: Pop (op code 1) reads the word at `sp_in`. It returns it on `result`, sets `sp_out = sp_in + 4` with `sp_we` set, and `pc_we` stays 0.
- R3: A pop with `dst_is_sp` set returns the loaded word on `sp_out` in place of the incremented pointer.
- R4: Call (op code 2) writes `call_pc + 5` to `sp_in - 4`. It returns `sp_out = sp_in - 4`, `result = call_pc + 5`, `next_pc = call_dest` and a `pc_we` pulse.
- R5: Return (op code 3) reads the word at `sp_in`. It returns it on both `result` and `next_pc` with a `pc_we` pulse, and sets `sp_out = sp_in + 4`.
- R6: An access is in range only when its address plus 4 is at most `MEM_BYTES`; the push and call address `sp_in - 4` wraps modulo 2^32. An out-of-range operation makes no memory access, ends with `stat = 3`, keeps `sp_we` and `pc_we` at 0, and sets `result` to 0.
- R7: `done` is high for exactly one cycle, after the third rising edge counting the edge that samples `start`. A successful operation reports `stat = 1`. After reset `done`, `mem_req`, `sp_we` and `pc_we` are 0 and `stat` is 1.
- R8: An in-range operation raises `mem_req` for exactly one cycle, directly after the start edge. `mem_we` is 1 for push and call and 0 for pop and return.
- R9: A stack pointer that is not a multiple of 4 is used unchanged as the byte address. The memory port assembles the word little-endian from four consecutive bytes.
- R10: `start` is ignored while an operation is in progress, so the running operation's results and access count are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op | input | 2 | 0 push, 1 pop, 2 call, 3 return |
| sp_in | input | 32 | Current stack pointer |
| src_data | input | 32 | Word to push |
| call_pc | input | 32 | Address of the call instruction |
| call_dest | input | 32 | Call target address |
| dst_is_sp | input | 1 | Pop destination is the stack pointer |
| done | output | 1 | One-cycle completion pulse |
| stat | output | 3 | 1 normal, 3 bad address |
| sp_we | output | 1 | Stack pointer write strobe, with done |
| sp_out | output | 32 | New stack pointer value |
| pc_we | output | 1 | Program counter write strobe, with done |
| next_pc | output | 32 | Next program counter for call or return |
| result | output | 32 | Word stored or loaded |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write word |
| mem_rdata | input | 32 | Read word, valid the cycle after the strobe edge |

## Verification
The hardest situations to reach are the range boundaries. A push from a pointer below 4 must wrap and be refused, while a pointer of exactly 4 or a pop at `MEM_BYTES - 4` must succeed. Directed cases hit each edge on both sides, including misaligned pointers. Seeded random stimulus draws pointers that reach past the top of memory. A second `start` is also pulsed in mid-operation to show that it leaves the access count and the results alone.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_CALL = 2'd2,
    OP_RET  = 2'd3
  } stk_op_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_REQ,
    S_RESP
  } stk_state_e;

  localparam logic [2:0] ST_OK     = 3'd1;
  localparam logic [2:0] ST_BADADR = 3'd3;
endpackage

// File: rtl/stk_addr_unit.sv
module stk_addr_unit
  import stk_pkg::*;
#(
  parameter int AW         = 32,
  parameter int MEM_BYTES  = 256,
  parameter int WORD_BYTES = 4
) (
  input  stk_op_e       op,
  input  logic [AW-1:0] sp,
  output logic [AW-1:0] addr,
  output logic          in_range
);
  localparam logic [AW:0] LIMIT = (AW+1)'(MEM_BYTES);
  localparam logic [AW:0] WB    = (AW+1)'(WORD_BYTES);

  logic          grows_down;
  logic [AW:0]   end_x;

  always_comb begin
    grows_down = (op == OP_PUSH) || (op == OP_CALL);
    addr       = grows_down ? sp - AW'(WORD_BYTES) : sp;
    end_x      = {1'b0, addr} + WB;
    in_range   = (end_x <= LIMIT);
  end
endmodule

// File: rtl/stk_result_unit.sv
module stk_result_unit
  import stk_pkg::*;
#(
  parameter int AW         = 32,
  parameter int WORD_BYTES = 4
) (
  input  stk_op_e       op,
  input  logic          ok,
  input  logic          dst_sp,
  input  logic [AW-1:0] sp,
  input  logic [AW-1:0] rdata,
  input  logic [AW-1:0] wdata,
  input  logic [AW-1:0] dest,
  output logic [AW-1:0] sp_nxt,
  output logic          sp_wr,
  output logic [AW-1:0] pc_nxt,
  output logic          pc_wr,
  output logic [AW-1:0] res
);
  always_comb begin
    sp_nxt = sp;
    sp_wr  = 1'b0;
    pc_nxt = '0;
    pc_wr  = 1'b0;
    res    = '0;
    if (ok) begin
      unique case (op)
        OP_PUSH: begin
          sp_nxt = sp - AW'(WORD_BYTES);
          sp_wr  = 1'b1;
          res    = wdata;
        end
        OP_CALL: begin
          sp_nxt = sp - AW'(WORD_BYTES);
          sp_wr  = 1'b1;
          res    = wdata;
          pc_nxt = dest;
          pc_wr  = 1'b1;
        end
        OP_POP: begin
          sp_nxt = dst_sp ? rdata : sp + AW'(WORD_BYTES);
          sp_wr  = 1'b1;
          res    = rdata;
        end
        OP_RET: begin
          sp_nxt = sp + AW'(WORD_BYTES);
          sp_wr  = 1'b1;
          res    = rdata;
          pc_nxt = rdata;
          pc_wr  = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/stack_engine.sv
module stack_engine
  import stk_pkg::*;
#(
  parameter int AW         = 32,
  parameter int MEM_BYTES  = 256,
  parameter int WORD_BYTES = 4,
  parameter int CALL_LEN   = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [AW-1:0] sp_in,
  input  logic [AW-1:0] src_data,
  input  logic [AW-1:0] call_pc,
  input  logic [AW-1:0] call_dest,
  input  logic          dst_is_sp,
  output logic          done,
  output logic [2:0]    stat,
  output logic          sp_we,
  output logic [AW-1:0] sp_out,
  output logic          pc_we,
  output logic [AW-1:0] next_pc,
  output logic [AW-1:0] result,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic [AW-1:0] mem_rdata
);
  stk_state_e    state;
  stk_op_e       op_in, op_q;
  logic [AW-1:0] sp_q, wdat_q, dest_q;
  logic          dsp_q, ok_q;

  logic [AW-1:0] acc_addr;
  logic          acc_ok;
  logic [AW-1:0] wval;
  logic [AW-1:0] r_sp, r_pc, r_res;
  logic          r_spwe, r_pcwe;

  assign op_in = stk_op_e'(op);
  assign wval  = (op_in == OP_CALL) ? call_pc + AW'(CALL_LEN) : src_data;

  stk_addr_unit #(.AW(AW), .MEM_BYTES(MEM_BYTES), .WORD_BYTES(WORD_BYTES)) addr_i (
    .op(op_in), .sp(sp_in), .addr(acc_addr), .in_range(acc_ok)
  );

  stk_result_unit #(.AW(AW), .WORD_BYTES(WORD_BYTES)) res_i (
    .op(op_q), .ok(ok_q), .dst_sp(dsp_q), .sp(sp_q), .rdata(mem_rdata),
    .wdata(wdat_q), .dest(dest_q), .sp_nxt(r_sp), .sp_wr(r_spwe),
    .pc_nxt(r_pc), .pc_wr(r_pcwe), .res(r_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      op_q      <= OP_PUSH;
      sp_q      <= '0;
      wdat_q    <= '0;
      dest_q    <= '0;
      dsp_q     <= 1'b0;
      ok_q      <= 1'b0;
      done      <= 1'b0;
      stat      <= ST_OK;
      sp_we     <= 1'b0;
      sp_out    <= '0;
      pc_we     <= 1'b0;
      next_pc   <= '0;
      result    <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          done  <= 1'b0;
          sp_we <= 1'b0;
          pc_we <= 1'b0;
          if (start) begin
            op_q      <= op_in;
            sp_q      <= sp_in;
            wdat_q    <= wval;
            dest_q    <= call_dest;
            dsp_q     <= dst_is_sp;
            ok_q      <= acc_ok;
            mem_req   <= acc_ok;
            mem_we    <= (op_in == OP_PUSH) || (op_in == OP_CALL);
            mem_addr  <= acc_addr;
            mem_wdata <= wval;
            state     <= S_REQ;
          end
        end
        S_REQ: begin
          mem_req <= 1'b0;
          state   <= S_RESP;
        end
        S_RESP: begin
          done    <= 1'b1;
          stat    <= ok_q ? ST_OK : ST_BADADR;
          sp_we   <= r_spwe;
          sp_out  <= r_sp;
          pc_we   <= r_pcwe;
          next_pc <= r_pc;
          result  <= r_res;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R8
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst) mem_req |=> !mem_req);

  // R7
  strobe_to_done_chk: assert property (@(posedge clk) disable iff (rst) mem_req |=> ##1 done);

  // R6
  bad_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (done && stat == ST_BADADR) |-> (!sp_we && !pc_we));

  // R6
  strobe_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> ({1'b0, mem_addr} + (AW+1)'(WORD_BYTES) <= (AW+1)'(MEM_BYTES)));

  // R4
  pc_only_flow_chk: assert property (@(posedge clk) disable iff (rst)
    pc_we |-> (done && (op_q == OP_CALL || op_q == OP_RET)));
endmodule

// File: tb/stack_engine_tb.sv
module stack_engine_tb_top;
  localparam int MB = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [31:0] sp_in = '0, src_data = '0, call_pc = '0, call_dest = '0;
  logic        dst_is_sp = 1'b0;
  logic        done, sp_we, pc_we, mem_req, mem_we;
  logic [2:0]  stat;
  logic [31:0] sp_out, next_pc, result, mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  logic [7:0]  mem [MB];
  int          strobes = 0;
  int          n_chk = 0, n_bad = 0;
  int          cyc = 0;

  always #5 clk = ~clk;

  stack_engine #(.MEM_BYTES(MB)) dut_i (
    .clk(clk), .rst(rst), .start(start), .op(op), .sp_in(sp_in),
    .src_data(src_data), .call_pc(call_pc), .call_dest(call_dest),
    .dst_is_sp(dst_is_sp), .done(done), .stat(stat), .sp_we(sp_we),
    .sp_out(sp_out), .pc_we(pc_we), .next_pc(next_pc), .result(result),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Byte-wide little-endian memory model
  always @(posedge clk) begin
    if (mem_req) begin
      strobes <= strobes + 1;
      if (mem_we) begin
        for (int i = 0; i < 4; i++) mem[8'(mem_addr + 32'(i))] <= mem_wdata[8*i +: 8];
      end else begin
        mem_rdata <= {mem[8'(mem_addr + 32'd3)], mem[8'(mem_addr + 32'd2)],
                      mem[8'(mem_addr + 32'd1)], mem[8'(mem_addr)]};
      end
    end
  end

  function automatic logic [31:0] rd_word(logic [31:0] a);
    return {mem[8'(a + 32'd3)], mem[8'(a + 32'd2)], mem[8'(a + 32'd1)], mem[8'(a)]};
  endfunction

  function automatic logic in_rng(logic [31:0] a);
    return ({1'b0, a} + 33'd4) <= 33'(MB);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_op(logic [1:0] o, logic [31:0] sp, logic [31:0] src,
                       logic [31:0] cpc, logic [31:0] dst, logic dsp,
                       logic poke, string tag);
    logic        down, ok, wr;
    logic [31:0] a, wv, e_sp, e_pc, e_res, loaded;
    logic        e_spwe, e_pcwe;
    int          s0;
    down   = (o == 2'd0) || (o == 2'd2);
    a      = down ? sp - 32'd4 : sp;
    ok     = in_rng(a);
    wr     = down;
    wv     = (o == 2'd2) ? cpc + 32'd5 : src;
    loaded = ok ? rd_word(a) : 32'd0;
    e_spwe = ok;
    e_pcwe = ok && (o >= 2'd2);
    e_sp   = down ? sp - 32'd4 : ((o == 2'd1 && dsp) ? loaded : sp + 32'd4);
    e_res  = !ok ? 32'd0 : (wr ? wv : loaded);
    e_pc   = (o == 2'd2) ? dst : loaded;

    @(negedge clk);
    s0 = strobes;
    op = o; sp_in = sp; src_data = src; call_pc = cpc; call_dest = dst;
    dst_is_sp = dsp; start = 1'b1;
    @(posedge clk); @(negedge clk);
    if (poke) begin
      start = 1'b1; op = 2'd0; sp_in = 32'd64; src_data = 32'hDEAD_BEEF;
    end else start = 1'b0;
    check("R8 strobe", {31'd0, mem_req}, {31'd0, ok});
    check("R7 early done", {31'd0, done}, 32'd0);
    if (ok) begin
      check("R9 addr", mem_addr, a);
      check("R8 we", {31'd0, mem_we}, {31'd0, wr});
    end
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    check("R7 early done", {31'd0, done}, 32'd0);
    @(posedge clk); @(negedge clk);
    check("R7 done", {31'd0, done}, 32'd1);
    check(ok ? "R7 stat" : "R6 stat", {29'd0, stat}, ok ? 32'd1 : 32'd3);
    check(ok ? tag : "R6", {31'd0, sp_we}, {31'd0, e_spwe});
    check(ok ? tag : "R6", {31'd0, pc_we}, {31'd0, e_pcwe});
    check(ok ? tag : "R6", result, e_res);
    if (e_spwe) check(tag, sp_out, e_sp);
    if (e_pcwe) check(tag, next_pc, e_pc);
    check(poke ? "R10 strobes" : "R8 strobes", 32'(strobes - s0), ok ? 32'd1 : 32'd0);
    @(posedge clk); @(negedge clk);
    check("R7 pulse", {31'd0, done}, 32'd0);
    check("R7 pulse", {30'd0, sp_we, pc_we}, 32'd0);
    check(poke ? "R10 idle" : "R8 idle", {31'd0, mem_req}, 32'd0);
    if (ok && wr) check(tag, rd_word(a), wv);
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] rsp;
    logic [1:0]  ro;
    void'($urandom(32'd20240611));
    for (int i = 0; i < MB; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R7 reset state
    check("R7 reset done", {31'd0, done}, 32'd0);
    check("R7 reset req", {31'd0, mem_req}, 32'd0);
    check("R7 reset we", {30'd0, sp_we, pc_we}, 32'd0);
    check("R7 reset stat", {29'd0, stat}, 32'd1);

    do_op(2'd0, 32'd128, 32'h1234_5678, 0, 0, 1'b0, 1'b0, "R1 push");
    do_op(2'd1, 32'd124, 0, 0, 0, 1'b0, 1'b0, "R2 pop");
    do_op(2'd0, 32'd101, 32'hA1B2_C3D4, 0, 0, 1'b0, 1'b0, "R9 push");
    do_op(2'd1, 32'd97, 0, 0, 0, 1'b0, 1'b0, "R9 pop");
    do_op(2'd1, 32'd40, 0, 0, 0, 1'b1, 1'b0, "R3 pop sp");
    do_op(2'd2, 32'd200, 0, 32'h0000_0040, 32'h0000_0080, 1'b0, 1'b0, "R4 call");
    do_op(2'd3, 32'd196, 0, 0, 0, 1'b0, 1'b0, "R5 ret");
    do_op(2'd1, 32'd252, 0, 0, 0, 1'b0, 1'b0, "R6 pop top edge");
    do_op(2'd1, 32'd253, 0, 0, 0, 1'b0, 1'b0, "R6 pop over");
    do_op(2'd0, 32'd4, 32'h0BAD_F00D, 0, 0, 1'b0, 1'b0, "R6 push low edge");
    do_op(2'd0, 32'd3, 32'h0BAD_F00D, 0, 0, 1'b0, 1'b0, "R6 push wrap");
    do_op(2'd2, 32'd2, 0, 32'h10, 32'h20, 1'b0, 1'b0, "R6 call wrap");
    do_op(2'd3, 32'd256, 0, 0, 0, 1'b0, 1'b0, "R6 ret over");
    do_op(2'd0, 32'd260, 32'h1, 0, 0, 1'b0, 1'b0, "R6 push over");
    do_op(2'd1, 32'd80, 0, 0, 0, 1'b0, 1'b1, "R10 pop poke");
    do_op(2'd2, 32'd150, 0, 32'h300, 32'h500, 1'b0, 1'b1, "R10 call poke");

    for (int k = 0; k < 80; k++) begin
      ro  = 2'($urandom % 4);
      rsp = ($urandom % 8 == 0) ? 32'($urandom % 300) : 32'(4 + $urandom % 252);
      do_op(ro, rsp, $urandom, $urandom, $urandom, 1'($urandom % 2), 1'($urandom % 4 == 0),
            ro == 2'd0 ? "R1 rnd" : ro == 2'd1 ? "R2 R3 rnd" : ro == 2'd2 ? "R4 rnd" : "R5 rnd");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule